// File: doc/BRIEF.md
# Unlock Sequence Command Decoder

This block turns a stream of single-cycle writes into command pulses for the control logic of a flash-style memory. Each write carries an address and a data word. Most commands begin with a fixed two-write unlock prefix. A third write then selects the operation. Erase commands need a setup code and a second unlock prefix before the final write. A few commands take a single write with no prefix: read array, suspend and resume.

The decoder produces one registered pulse per accepted command on a one-hot vector. It also keeps a two-bit read-source selector that tells the read path whether to return array data, identifier bytes, status or the page buffer.

A status tracker outside the block supplies three qualifiers: an erase is running, an erase is suspended, and an error lock is set. These qualifiers limit which commands take effect. A command that arrives in the wrong context is refused quietly. A write that breaks a sequence drops the decoder back to idle.

Top module: `cmdseq_decoder`

## Requirements
- R1: After reset the decoder is idle, `rd_src` is 0 (array), `cmd_pulse` is all zero and `blk_addr` is zero.
- R2: A sequence is entered only through data AAh at key address 5555h followed by data 55h at 2AAAh. Only address bits 14:0 and data bits 7:0 are compared; all higher address and data bits are ignored.
- R3: After the prefix, a write at 5555h with one of these codes issues the listed pulse bit and read source (unchanged where not listed):
  - 90h: read-ID pulse, bit 1, source 1
  - A0h: program pulse, bit 2, source 2
  - E0h: buffer-write pulse, bit 3
  - 75h: buffer-read pulse, bit 4, source 3
  - C0h: sleep pulse, bit 9, source 2
  - 70h: read-status pulse, bit 10, source 2
  - 50h: clear-status pulse, bit 11
  - 04h: clear-buffer pulse, bit 12
- R4: Erase is entered by the prefix, then 80h at 5555h, then a second prefix. The final write is either 10h at 5555h, which gives a chip-erase pulse (bit 5), or 30h at any address, which gives a block-erase pulse (bit 6). Both set source 2. A block erase also captures its full write address on `blk_addr`.
- R5: A single write of F0h at any address and in any sequence step gives a read-array pulse (bit 0), sets source 0 and returns the decoder to idle.
- R6: A write with a wrong value or address for its step gives no pulse and returns the decoder to idle. It sets source 0, except that source 3 (buffer) is kept.
- R7: A single write of B0h gives a suspend pulse (bit 7) only while an erase is running. A single write of 30h gives a resume pulse (bit 8) only while an erase is suspended. Suspend and resume both set source 2. Outside those contexts both codes have no effect: no pulse and no change of source.
- R8: While an erase is running and not suspended, every write other than B0h is ignored: no pulse, no change of source, and no progress through a sequence.
- R9: While an erase is suspended, only read array, resume and read status take effect. Any other completed command, including buffer read, sleep and erase setup, is refused: no pulse, source unchanged, decoder back to idle.
- R10: While the error lock is set and no erase is running or suspended, only clear status, read status and read array take effect. Other commands are refused as in R9.
- R11: A pulse appears in the clock cycle after the accepting write and lasts exactly one cycle. At most one bit of `cmd_pulse` is high at a time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | One write per cycle in which this is high |
| wr_addr | input | ADDR_W (20) | Write address; low 15 bits are compared |
| wr_data | input | DATA_W (16) | Write data; low byte is the command code |
| erase_run | input | 1 | Erase in progress (from status tracker) |
| erase_susp | input | 1 | Erase suspended (takes priority over erase_run) |
| err_lock | input | 1 | Error lockout active |
| cmd_pulse | output | 13 | One-hot command pulses, bit map as in R3 to R7 |
| rd_src | output | 2 | Read source: 0 array, 1 ID, 2 status, 3 buffer |
| blk_addr | output | ADDR_W (20) | Address captured by the last block erase |

## Verification
The bench probes whether the upper address and data bits are ignored by unlocking at a high address with a non-zero upper byte. A decoder that compared full words would never leave idle. It breaks sequences from the buffer source and from the ID source. A decoder that reset the source unconditionally, or never reset it, would show the wrong source on the next read.

The bench also sends a full unlock prefix while an erase runs, and then a lone code in normal mode. A decoder that stepped through the prefix while the erase ran would accept the stale sequence instead of treating the code as a broken sequence.

Refused commands are checked in every context, including buffer read and sleep during suspend, and suspend or resume with no erase. A design that filtered too little would emit a pulse. A design that treated a refusal as a sequence error would move the read source. Finally, a reset in mid-sequence must discard the prefix, so the following code must not complete a command.

// File: rtl/cmdseq_pkg.sv
`timescale 1ns/1ps
package cmdseq_pkg;

  localparam int NUM_CMD = 13;
  localparam int KEY_W   = 15;
  localparam int CODE_W  = 8;

  // pulse bit positions (bit map visible on cmd_pulse)
  localparam int C_RD_ARRAY = 0;
  localparam int C_RD_ID    = 1;
  localparam int C_PROG     = 2;
  localparam int C_BUF_WR   = 3;
  localparam int C_BUF_RD   = 4;
  localparam int C_CHIP_ER  = 5;
  localparam int C_BLK_ER   = 6;
  localparam int C_SUSPEND  = 7;
  localparam int C_RESUME   = 8;
  localparam int C_SLEEP    = 9;
  localparam int C_RD_STAT  = 10;
  localparam int C_CLR_STAT = 11;
  localparam int C_CLR_BUF  = 12;

  localparam logic [KEY_W-1:0]  KEY_ADDR_A = 15'h5555;
  localparam logic [KEY_W-1:0]  KEY_ADDR_B = 15'h2AAA;
  localparam logic [CODE_W-1:0] KEY_DATA_A = 8'hAA;
  localparam logic [CODE_W-1:0] KEY_DATA_B = 8'h55;
  localparam logic [CODE_W-1:0] OP_RESET   = 8'hF0;
  localparam logic [CODE_W-1:0] OP_SUSPEND = 8'hB0;
  localparam logic [CODE_W-1:0] OP_RESUME  = 8'h30;
  localparam logic [CODE_W-1:0] OP_SETUP   = 8'h80;
  localparam logic [CODE_W-1:0] OP_CHIP    = 8'h10;
  localparam logic [CODE_W-1:0] OP_BLOCK   = 8'h30;

  typedef enum logic [1:0] {
    SRC_ARRAY  = 2'd0,
    SRC_ID     = 2'd1,
    SRC_STATUS = 2'd2,
    SRC_BUFFER = 2'd3
  } rd_src_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_KEY1, ST_KEY2, ST_SETUP, ST_EKEY1, ST_EKEY2
  } seq_state_e;

  typedef enum logic [1:0] {
    MODE_NORMAL, MODE_RUN, MODE_SUSP, MODE_LOCK
  } mode_e;

  function automatic logic [NUM_CMD-1:0] cmd_bit(input int idx);
    logic [NUM_CMD-1:0] one;
    one = '0;
    one[0] = 1'b1;
    return one << idx;
  endfunction

  // commands selected by the write that follows the unlock prefix
  function automatic logic third_valid(input int idx);
    case (idx)
      C_RD_ID, C_PROG, C_BUF_WR, C_BUF_RD,
      C_SLEEP, C_RD_STAT, C_CLR_STAT, C_CLR_BUF: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic [CODE_W-1:0] third_code(input int idx);
    case (idx)
      C_RD_ID:    return 8'h90;
      C_PROG:     return 8'hA0;
      C_BUF_WR:   return 8'hE0;
      C_BUF_RD:   return 8'h75;
      C_SLEEP:    return 8'hC0;
      C_RD_STAT:  return 8'h70;
      C_CLR_STAT: return 8'h50;
      C_CLR_BUF:  return 8'h04;
      default:    return 8'h00;
    endcase
  endfunction

  // suspension outranks a running erase, which outranks the error lock
  function automatic mode_e mode_of(input logic susp, input logic run, input logic lock);
    if (susp)      return MODE_SUSP;
    else if (run)  return MODE_RUN;
    else if (lock) return MODE_LOCK;
    else           return MODE_NORMAL;
  endfunction

  function automatic logic [NUM_CMD-1:0] allow_mask(input mode_e m);
    case (m)
      MODE_RUN:  return cmd_bit(C_SUSPEND);
      MODE_SUSP: return cmd_bit(C_RD_ARRAY) | cmd_bit(C_RESUME) | cmd_bit(C_RD_STAT);
      MODE_LOCK: return cmd_bit(C_RD_ARRAY) | cmd_bit(C_RD_STAT) | cmd_bit(C_CLR_STAT);
      default:   return ~(cmd_bit(C_SUSPEND) | cmd_bit(C_RESUME));
    endcase
  endfunction

  function automatic logic [NUM_CMD-1:0] status_src_mask();
    return cmd_bit(C_PROG) | cmd_bit(C_CHIP_ER) | cmd_bit(C_BLK_ER) |
           cmd_bit(C_SUSPEND) | cmd_bit(C_RESUME) | cmd_bit(C_SLEEP) |
           cmd_bit(C_RD_STAT);
  endfunction

  function automatic rd_src_e src_after(input logic [NUM_CMD-1:0] grant,
                                        input rd_src_e cur, input logic seq_err);
    if (grant[C_RD_ARRAY])              return SRC_ARRAY;
    if (grant[C_RD_ID])                 return SRC_ID;
    if (grant[C_BUF_RD])                return SRC_BUFFER;
    if (|(grant & status_src_mask()))   return SRC_STATUS;
    if (|grant)                         return cur;
    if (seq_err) return (cur == SRC_BUFFER) ? SRC_BUFFER : SRC_ARRAY;
    return cur;
  endfunction

endpackage

// File: rtl/cmdseq_classify.sv
`timescale 1ns/1ps
module cmdseq_classify
  import cmdseq_pkg::*;
(
  input  logic [KEY_W-1:0]   key_addr,
  input  logic [CODE_W-1:0]  code,
  output logic               key1,
  output logic               key2,
  output logic               op_reset,
  output logic               op_suspend,
  output logic               op_resume,
  output logic               op_setup,
  output logic               op_chip,
  output logic               op_block,
  output logic [NUM_CMD-1:0] third_hit
);
  logic at_a, at_b;

  assign at_a = (key_addr == KEY_ADDR_A);
  assign at_b = (key_addr == KEY_ADDR_B);

  assign key1       = at_a && (code == KEY_DATA_A);
  assign key2       = at_b && (code == KEY_DATA_B);
  assign op_reset   = (code == OP_RESET);
  assign op_suspend = (code == OP_SUSPEND);
  assign op_resume  = (code == OP_RESUME);
  assign op_setup   = at_a && (code == OP_SETUP);
  assign op_chip    = at_a && (code == OP_CHIP);
  assign op_block   = (code == OP_BLOCK);

  for (genvar g = 0; g < NUM_CMD; g++) begin : g_third
    if (third_valid(g)) begin : g_cmp
      assign third_hit[g] = at_a && (code == third_code(g));
    end else begin : g_none
      assign third_hit[g] = 1'b0;
    end
  end
endmodule

// File: rtl/cmdseq_fsm.sv
`timescale 1ns/1ps
module cmdseq_fsm
  import cmdseq_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  mode_e              mode,
  input  logic [NUM_CMD-1:0] allow,
  input  logic               key1,
  input  logic               key2,
  input  logic               op_reset,
  input  logic               op_suspend,
  input  logic               op_resume,
  input  logic               op_setup,
  input  logic               op_chip,
  input  logic               op_block,
  input  logic [NUM_CMD-1:0] third_hit,
  output logic [NUM_CMD-1:0] raw_hit,
  output logic               seq_err
);
  seq_state_e st, st_nxt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st <= ST_IDLE;
    else        st <= st_nxt;
  end

  always_comb begin
    st_nxt  = st;
    raw_hit = '0;
    seq_err = 1'b0;
    if (wr_en) begin
      if (mode == MODE_RUN) begin
        // erase running: the sequencer is frozen, only suspend is seen
        st_nxt = ST_IDLE;
        raw_hit[C_SUSPEND] = op_suspend;
      end else if (op_reset) begin
        st_nxt = ST_IDLE;
        raw_hit[C_RD_ARRAY] = 1'b1;
      end else begin
        case (st)
          ST_IDLE: begin
            if (key1)            st_nxt = ST_KEY1;
            else if (op_suspend) raw_hit[C_SUSPEND] = 1'b1;
            else if (op_resume)  raw_hit[C_RESUME] = 1'b1;
            else                 seq_err = 1'b1;
          end
          ST_KEY1: begin
            if (key2) st_nxt = ST_KEY2;
            else begin st_nxt = ST_IDLE; seq_err = 1'b1; end
          end
          ST_KEY2: begin
            st_nxt = ST_IDLE;
            if (|third_hit) raw_hit = third_hit;
            else if (op_setup) begin
              if (allow[C_CHIP_ER] || allow[C_BLK_ER]) st_nxt = ST_SETUP;
            end
            else seq_err = 1'b1;
          end
          ST_SETUP: begin
            if (key1) st_nxt = ST_EKEY1;
            else begin st_nxt = ST_IDLE; seq_err = 1'b1; end
          end
          ST_EKEY1: begin
            if (key2) st_nxt = ST_EKEY2;
            else begin st_nxt = ST_IDLE; seq_err = 1'b1; end
          end
          ST_EKEY2: begin
            st_nxt = ST_IDLE;
            if (op_chip)       raw_hit[C_CHIP_ER] = 1'b1;
            else if (op_block) raw_hit[C_BLK_ER] = 1'b1;
            else               seq_err = 1'b1;
          end
          default: st_nxt = ST_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/cmdseq_gate.sv
`timescale 1ns/1ps
module cmdseq_gate
  import cmdseq_pkg::*;
(
  input  logic [NUM_CMD-1:0] raw_hit,
  input  logic [NUM_CMD-1:0] allow,
  output logic [NUM_CMD-1:0] grant
);
  for (genvar g = 0; g < NUM_CMD; g++) begin : g_bit
    assign grant[g] = raw_hit[g] & allow[g];
  end
endmodule

// File: rtl/cmdseq_outreg.sv
`timescale 1ns/1ps
module cmdseq_outreg
  import cmdseq_pkg::*;
#(
  parameter int ADDR_W = 20
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_CMD-1:0] grant,
  input  logic               seq_err,
  input  logic [ADDR_W-1:0]  wr_addr,
  output logic [NUM_CMD-1:0] pulse_q,
  output rd_src_e            src_q,
  output logic [ADDR_W-1:0]  blk_addr_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pulse_q    <= '0;
      src_q      <= SRC_ARRAY;
      blk_addr_q <= '0;
    end else begin
      pulse_q <= grant;
      src_q   <= src_after(grant, src_q, seq_err);
      if (grant[C_BLK_ER]) blk_addr_q <= wr_addr;
    end
  end
endmodule

// File: rtl/cmdseq_decoder.sv
`timescale 1ns/1ps
module cmdseq_decoder
  import cmdseq_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [ADDR_W-1:0]  wr_addr,
  input  logic [DATA_W-1:0]  wr_data,
  input  logic               erase_run,
  input  logic               erase_susp,
  input  logic               err_lock,
  output logic [NUM_CMD-1:0] cmd_pulse,
  output logic [1:0]         rd_src,
  output logic [ADDR_W-1:0]  blk_addr
);
  localparam int HI_W = DATA_W - CODE_W;

  // named internal events, visible to the bound checker
  logic               ev_key1, ev_key2, ev_seq_err;
  logic               op_reset, op_suspend, op_resume, op_setup, op_chip, op_block;
  logic [NUM_CMD-1:0] third_hit, raw_hit, grant, allow;
  mode_e              mode;
  rd_src_e            src_q;
  logic [HI_W-1:0]    unused_hi_byte;

  assign unused_hi_byte = wr_data[DATA_W-1:CODE_W];
  assign mode  = mode_of(erase_susp, erase_run, err_lock);
  assign allow = allow_mask(mode);

  cmdseq_classify u_classify (
    .key_addr   (wr_addr[KEY_W-1:0]),
    .code       (wr_data[CODE_W-1:0]),
    .key1       (ev_key1),
    .key2       (ev_key2),
    .op_reset   (op_reset),
    .op_suspend (op_suspend),
    .op_resume  (op_resume),
    .op_setup   (op_setup),
    .op_chip    (op_chip),
    .op_block   (op_block),
    .third_hit  (third_hit)
  );

  cmdseq_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .mode       (mode),
    .allow      (allow),
    .key1       (ev_key1),
    .key2       (ev_key2),
    .op_reset   (op_reset),
    .op_suspend (op_suspend),
    .op_resume  (op_resume),
    .op_setup   (op_setup),
    .op_chip    (op_chip),
    .op_block   (op_block),
    .third_hit  (third_hit),
    .raw_hit    (raw_hit),
    .seq_err    (ev_seq_err)
  );

  cmdseq_gate u_gate (
    .raw_hit (raw_hit),
    .allow   (allow),
    .grant   (grant)
  );

  cmdseq_outreg #(.ADDR_W(ADDR_W)) u_out (
    .clk        (clk),
    .rst_n      (rst_n),
    .grant      (grant),
    .seq_err    (ev_seq_err),
    .wr_addr    (wr_addr),
    .pulse_q    (cmd_pulse),
    .src_q      (src_q),
    .blk_addr_q (blk_addr)
  );

  assign rd_src = src_q;
endmodule

// File: rtl/cmdseq_checker.sv
`timescale 1ns/1ps
module cmdseq_checker
  import cmdseq_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic               wr_en,
  input logic               erase_run,
  input logic               erase_susp,
  input logic               err_lock,
  input logic               ev_seq_err,
  input logic [NUM_CMD-1:0] cmd_pulse,
  input logic [1:0]         rd_src
);
  localparam logic [NUM_CMD-1:0] M_SUSP_OK = 13'h0401 | 13'h0100;
  localparam logic [NUM_CMD-1:0] M_LOCK_OK = 13'h0401 | 13'h0800;
  localparam logic [NUM_CMD-1:0] M_RUN_OK  = 13'h0080;

  a_r11_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(cmd_pulse));

  a_r11_after_write: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_pulse != '0) |-> $past(wr_en));

  a_r8_run_only_suspend: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && erase_run && !erase_susp) |=> ((cmd_pulse & ~M_RUN_OK) == '0));

  a_r9_susp_filter: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && erase_susp) |=> ((cmd_pulse & ~M_SUSP_OK) == '0));

  a_r10_lock_filter: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && err_lock && !erase_run && !erase_susp) |=> ((cmd_pulse & ~M_LOCK_OK) == '0));

  a_r7_suspend_ctx: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_pulse[C_SUSPEND] |-> $past(erase_run && !erase_susp));

  a_r7_resume_ctx: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_pulse[C_RESUME] |-> $past(erase_susp));

  a_r5_array_src: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_pulse[C_RD_ARRAY] |-> (rd_src == 2'd0));

  a_r6_err_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && ev_seq_err) |=> (cmd_pulse == '0));
endmodule

bind cmdseq_decoder cmdseq_checker u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .wr_en      (wr_en),
  .erase_run  (erase_run),
  .erase_susp (erase_susp),
  .err_lock   (err_lock),
  .ev_seq_err (ev_seq_err),
  .cmd_pulse  (cmd_pulse),
  .rd_src     (rd_src)
);

// File: tb/test_cmdseq_decoder.sv
`timescale 1ns/1ps
module test_cmdseq_decoder;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [19:0] wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic        erase_run = 1'b0;
  logic        erase_susp = 1'b0;
  logic        err_lock = 1'b0;
  logic [12:0] cmd_pulse;
  logic [1:0]  rd_src;
  logic [19:0] blk_addr;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  cmdseq_decoder i_cmdseq_decoder (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .erase_run(erase_run), .erase_susp(erase_susp), .err_lock(err_lock),
    .cmd_pulse(cmd_pulse), .rd_src(rd_src), .blk_addr(blk_addr)
  );

  typedef struct packed {
    logic [3:0]  req;
    logic [2:0]  mode;   // {suspended, running, locked}
    logic [19:0] addr;
    logic [15:0] data;
    logic [12:0] pulse;
    logic [1:0]  src;
  } vec_t;

  localparam logic [2:0]  NM = 3'b000, RN = 3'b010, SU = 3'b100, LK = 3'b001;
  localparam logic [19:0] A5 = 20'h05555, A2 = 20'h02AAA, AZ = 20'h00000;
  localparam logic [12:0] P0 = 13'h0000, P_RA = 13'h0001, P_ID = 13'h0002,
                          P_PG = 13'h0004, P_BW = 13'h0008, P_BR = 13'h0010,
                          P_CE = 13'h0020, P_BE = 13'h0040, P_SP = 13'h0080,
                          P_RE = 13'h0100, P_SL = 13'h0200, P_RS = 13'h0400,
                          P_CS = 13'h0800, P_CB = 13'h1000;

  localparam int NV = 79;
  localparam vec_t VEC [NV] = '{
    // R2 prefix, R3 read ID
    {4'd2, NM, A5, 16'h00AA, P0, 2'd0},
    {4'd2, NM, A2, 16'h0055, P0, 2'd0},
    {4'd3, NM, A5, 16'h0090, P_ID, 2'd1},
    // R6 wrong order from ID source
    {4'd6, NM, A5, 16'h00AA, P0, 2'd1},
    {4'd6, NM, A5, 16'h00AA, P0, 2'd0},
    // R2 upper address and data bits ignored, R3 buffer read
    {4'd2, NM, 20'hF5555, 16'hFFAA, P0, 2'd0},
    {4'd2, NM, 20'hA2AAA, 16'hC355, P0, 2'd0},
    {4'd3, NM, A5, 16'h0075, P_BR, 2'd3},
    // R6 broken sequence keeps buffer source
    {4'd6, NM, A2, 16'h0055, P0, 2'd3},
    // R5 read array
    {4'd5, NM, 20'h07FFF, 16'h00F0, P_RA, 2'd0},
    // R3 program
    {4'd2, NM, A5, 16'h00AA, P0, 2'd0},
    {4'd2, NM, A2, 16'h0055, P0, 2'd0},
    {4'd3, NM, A5, 16'h00A0, P_PG, 2'd2},
    {4'd5, NM, AZ, 16'h00F0, P_RA, 2'd0},
    // R4 block erase
    {4'd4, NM, A5, 16'h00AA, P0, 2'd0},
    {4'd4, NM, A2, 16'h0055, P0, 2'd0},
    {4'd4, NM, A5, 16'h0080, P0, 2'd0},
    {4'd4, NM, A5, 16'h00AA, P0, 2'd0},
    {4'd4, NM, A2, 16'h0055, P0, 2'd0},
    {4'd4, NM, 20'h01ABC, 16'h0030, P_BE, 2'd2},
    // R4 chip erase
    {4'd4, NM, A5, 16'h00AA, P0, 2'd2},
    {4'd4, NM, A2, 16'h0055, P0, 2'd2},
    {4'd4, NM, A5, 16'h0080, P0, 2'd2},
    {4'd4, NM, A5, 16'h00AA, P0, 2'd2},
    {4'd4, NM, A2, 16'h0055, P0, 2'd2},
    {4'd4, NM, A5, 16'h0010, P_CE, 2'd2},
    // R7 suspend while running, R8 prefix ignored while running
    {4'd7, RN, AZ, 16'h00B0, P_SP, 2'd2},
    {4'd8, RN, A5, 16'h00AA, P0, 2'd2},
    {4'd8, RN, A2, 16'h0055, P0, 2'd2},
    {4'd8, RN, A5, 16'h0090, P0, 2'd2},
    {4'd8, NM, A5, 16'h0090, P0, 2'd0},
    // R7 resume, R9 suspended filter
    {4'd7, SU, AZ, 16'h0030, P_RE, 2'd2},
    {4'd9, SU, A5, 16'h00AA, P0, 2'd2},
    {4'd9, SU, A2, 16'h0055, P0, 2'd2},
    {4'd9, SU, A5, 16'h0075, P0, 2'd2},
    {4'd9, SU, AZ, 16'h00F0, P_RA, 2'd0},
    {4'd7, SU, AZ, 16'h00B0, P0, 2'd0},
    {4'd9, SU, A5, 16'h00AA, P0, 2'd0},
    {4'd9, SU, A2, 16'h0055, P0, 2'd0},
    {4'd9, SU, A5, 16'h0070, P_RS, 2'd2},
    // R10 error lock filter
    {4'd10, LK, A5, 16'h00AA, P0, 2'd2},
    {4'd10, LK, A2, 16'h0055, P0, 2'd2},
    {4'd10, LK, A5, 16'h0050, P_CS, 2'd2},
    {4'd10, LK, A5, 16'h00AA, P0, 2'd2},
    {4'd10, LK, A2, 16'h0055, P0, 2'd2},
    {4'd10, LK, A5, 16'h0090, P0, 2'd2},
    {4'd10, LK, AZ, 16'h00F0, P_RA, 2'd0},
    // R7 suspend and resume ignored with no erase (ID source kept)
    {4'd3, NM, A5, 16'h00AA, P0, 2'd0},
    {4'd3, NM, A2, 16'h0055, P0, 2'd0},
    {4'd3, NM, A5, 16'h0090, P_ID, 2'd1},
    {4'd7, NM, AZ, 16'h00B0, P0, 2'd1},
    {4'd7, NM, AZ, 16'h0030, P0, 2'd1},
    // R3 remaining third-cycle codes
    {4'd3, NM, A5, 16'h00AA, P0, 2'd1},
    {4'd3, NM, A2, 16'h0055, P0, 2'd1},
    {4'd3, NM, A5, 16'h00C0, P_SL, 2'd2},
    {4'd3, NM, A5, 16'h00AA, P0, 2'd2},
    {4'd3, NM, A2, 16'h0055, P0, 2'd2},
    {4'd3, NM, A5, 16'h00E0, P_BW, 2'd2},
    {4'd3, NM, A5, 16'h00AA, P0, 2'd2},
    {4'd3, NM, A2, 16'h0055, P0, 2'd2},
    {4'd3, NM, A5, 16'h0004, P_CB, 2'd2},
    {4'd3, NM, A5, 16'h00AA, P0, 2'd2},
    {4'd3, NM, A2, 16'h0055, P0, 2'd2},
    {4'd3, NM, A5, 16'h0070, P_RS, 2'd2},
    {4'd3, NM, A5, 16'h00AA, P0, 2'd2},
    {4'd3, NM, A2, 16'h0055, P0, 2'd2},
    {4'd3, NM, A5, 16'h0050, P_CS, 2'd2},
    // R6 chip code at wrong address ends the erase sequence
    {4'd6, NM, A5, 16'h00AA, P0, 2'd2},
    {4'd6, NM, A2, 16'h0055, P0, 2'd2},
    {4'd6, NM, A5, 16'h0080, P0, 2'd2},
    {4'd6, NM, A5, 16'h00AA, P0, 2'd2},
    {4'd6, NM, A2, 16'h0055, P0, 2'd2},
    {4'd6, NM, 20'h01000, 16'h0010, P0, 2'd0},
    // R9 sleep refused while suspended
    {4'd9, SU, A5, 16'h00AA, P0, 2'd0},
    {4'd9, SU, A2, 16'h0055, P0, 2'd0},
    {4'd9, SU, A5, 16'h00C0, P0, 2'd0},
    // R6 unknown third-cycle code
    {4'd6, NM, A5, 16'h00AA, P0, 2'd0},
    {4'd6, NM, A2, 16'h0055, P0, 2'd0},
    {4'd6, NM, A5, 16'h0033, P0, 2'd0}
  };

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // called at a falling edge; returns one falling edge later with outputs updated
  task automatic wr(input logic [2:0] m, input logic [19:0] a, input logic [15:0] d);
    {erase_susp, erase_run, err_lock} = m;
    wr_addr = a;
    wr_data = d;
    wr_en   = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL R11 watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1", "pulse", 32'(cmd_pulse), 32'h0);
    chk("R1", "src", 32'(rd_src), 32'h0);
    chk("R1", "blk_addr", 32'(blk_addr), 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "src after release", 32'(rd_src), 32'h0);

    for (int i = 0; i < NV; i++) begin
      vec_t v;
      v = VEC[i];
      wr(v.mode, v.addr, v.data);
      chk($sformatf("R%0d", v.req), $sformatf("vec%0d pulse", i), 32'(cmd_pulse), 32'(v.pulse));
      chk($sformatf("R%0d", v.req), $sformatf("vec%0d src", i), 32'(rd_src), 32'(v.src));
    end

    // R4 block erase address capture, R11 single-cycle pulse
    wr(NM, A5, 16'h00AA);
    wr(NM, A2, 16'h0055);
    wr(NM, A5, 16'h0080);
    wr(NM, A5, 16'h00AA);
    wr(NM, A2, 16'h0055);
    wr(NM, 20'h3C456, 16'h0030);
    chk("R4", "block pulse", 32'(cmd_pulse), 32'(P_BE));
    chk("R4", "blk_addr", 32'(blk_addr), 32'h3C456);
    @(negedge clk);
    chk("R11", "pulse one cycle", 32'(cmd_pulse), 32'h0);
    chk("R4", "blk_addr held", 32'(blk_addr), 32'h3C456);

    // R1 reset in mid-sequence drops the prefix
    wr(NM, A5, 16'h00AA);
    wr(NM, A2, 16'h0055);
    rst_n = 1'b0;
    @(negedge clk);
    chk("R1", "src in reset", 32'(rd_src), 32'h0);
    chk("R1", "blk_addr in reset", 32'(blk_addr), 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    wr(NM, A5, 16'h0090);
    chk("R6", "stale prefix pulse", 32'(cmd_pulse), 32'h0);
    chk("R6", "stale prefix src", 32'(rd_src), 32'h0);

    // R2 a key address with a non-key value breaks the prefix
    wr(NM, A5, 16'h00AB);
    wr(NM, A2, 16'h0055);
    wr(NM, A5, 16'h0090);
    chk("R2", "bad key data", 32'(cmd_pulse), 32'h0);

    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule